// File: doc/BRIEF.md
# Dual-Lane Fixed-Point Multiply-Accumulate Unit

This block is a single arithmetic slot of a wide-issue signal-processing datapath. Each issued operation carries a 3-bit opcode, two 32-bit source words, a 40-bit accumulator word and a predicate bit. The slot can work on each source word as one signed 32-bit scalar or as a pair of signed 16-bit halfwords. A halfword pair is read either as two independent lanes or as one complex number, with the real part in the low half and the imaginary part in the high half.

Scalar work uses a full-precision 32x32 product and a 40-bit accumulator that wraps. Halfword work saturates every lane result to the signed 16-bit range. A separate opcode clamps a 40-bit accumulator into the signed 32-bit range. The unit takes one operation per cycle and gives a result two cycles later. When the predicate is false, the result is the incoming accumulator word, unchanged.

Top module: `simd_mac_unit`

## Requirements
- R1: An operation presented with `in_valid` high before clock edge k gives `out_valid` high after edge k+1. The unit accepts a new operation on every cycle. A cycle with `in_valid` low gives `out_valid` low two edges later.
- R2: Opcode 000 (scalar multiply): the result is the low 40 bits of the signed 32x32 product of `in_src_a` and `in_src_b`.
- R3: Opcode 001 (scalar multiply-accumulate): the result is `in_acc` plus the signed 64-bit product, taken modulo 2^40 (two's complement wrap).
- R4: For halfword opcodes (010, 011, 100), element 0 (or the real part) sits in bits [15:0] and element 1 (or the imaginary part) sits in bits [31:16]. This layout applies to both sources, to the accumulator lanes and to the result. Result bits [39:32] are zero, and `in_acc` bits [39:32] are ignored.
- R5: Opcode 010 (dual halfword multiply): each result lane is the signed 16x16 product of the matching source lanes, saturated to [-32768, 32767].
- R6: Opcode 011 (dual halfword multiply-accumulate): each result lane is the accumulator lane plus the matching lane product, saturated to the signed 16-bit range.
- R7: Opcode 100 (complex multiply-accumulate): real = acc_re + a_re*b_re - a_im*b_im and imag = acc_im + a_re*b_im + a_im*b_re. Each part is computed exactly and then saturated to the signed 16-bit range.
- R8: Opcode 101 (clamp): the signed 40-bit `in_acc` is clamped to [-2^31, 2^31-1] and sign-extended to 40 bits.
- R9: With `in_pred` low, the result equals `in_acc` for every opcode, and `out_valid` still follows R1.
- R10: Opcodes 110 and 111 return `in_acc` unchanged.
- R11: While `rst_n` is low, `out_valid` and `out_result` are zero.
- R12: `out_result` keeps its value on every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_pred | input | 1 | Predicate; low suppresses the update |
| in_op | input | 3 | Opcode |
| in_src_a | input | 32 | First source word |
| in_src_b | input | 32 | Second source word |
| in_acc | input | 40 | Accumulator word |
| out_valid | output | 1 | Result strobe |
| out_result | output | 40 | Result word |

## Verification
The assertions assume that `in_valid` is driven to a known level in every cycle after reset. They also assume that `in_pred`, `in_op` and `in_acc` are stable and meaningful whenever `in_valid` is high. The bench changes inputs only on the falling clock edge and holds them there. It parks the unused data inputs at arbitrary values while `in_valid` is low, so those values cannot leak into the result.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int LANE_W = 16;
  localparam int WORD_W = 2 * LANE_W;
  localparam int ACC_W  = 40;
  localparam int PROD_W = 2 * LANE_W;
  localparam int WIDE_W = 2 * WORD_W;
  localparam int SUM_W  = PROD_W + 3;
  localparam int NPROD  = 4;

  localparam logic [2:0] OP_SMUL  = 3'b000;
  localparam logic [2:0] OP_SMAC  = 3'b001;
  localparam logic [2:0] OP_VMUL  = 3'b010;
  localparam logic [2:0] OP_VMAC  = 3'b011;
  localparam logic [2:0] OP_CMAC  = 3'b100;
  localparam logic [2:0] OP_SAT32 = 3'b101;

  localparam logic signed [SUM_W-1:0] LANE_MAX = SUM_W'((1 << (LANE_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LANE_MIN = -LANE_MAX - SUM_W'(1);

  function automatic logic [LANE_W-1:0] sat_lane(input logic signed [SUM_W-1:0] x);
    if (x > LANE_MAX)      return {1'b0, {(LANE_W-1){1'b1}}};
    else if (x < LANE_MIN) return {1'b1, {(LANE_W-1){1'b0}}};
    else                   return x[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/simd_mac_mul.sv
module simd_mac_mul
  import simd_mac_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_pred,
  input  logic [2:0]                  in_op,
  input  logic [WORD_W-1:0]           in_src_a,
  input  logic [WORD_W-1:0]           in_src_b,
  input  logic [ACC_W-1:0]            in_acc,
  output logic                        s1_valid,
  output logic                        s1_pred,
  output logic [2:0]                  s1_op,
  output logic [ACC_W-1:0]            s1_acc,
  output logic [WIDE_W-1:0]           s1_wide,
  output logic [NPROD*PROD_W-1:0]     s1_lane_prod
);
  logic [WIDE_W-1:0]       wide_d;
  logic [NPROD*PROD_W-1:0] lane_d;

  // Full-width scalar product
  always_comb begin
    wide_d = $signed(in_src_a) * $signed(in_src_b);
  end

  // Every lane of a times every lane of b: index = i*2 + j
  for (genvar i = 0; i < 2; i++) begin : g_a
    for (genvar j = 0; j < 2; j++) begin : g_b
      logic signed [PROD_W-1:0] p;
      always_comb begin
        p = $signed(in_src_a[i*LANE_W +: LANE_W]) * $signed(in_src_b[j*LANE_W +: LANE_W]);
      end
      assign lane_d[(i*2+j)*PROD_W +: PROD_W] = p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_pred      <= in_pred;
      s1_op        <= in_op;
      s1_acc       <= in_acc;
      s1_wide      <= wide_d;
      s1_lane_prod <= lane_d;
    end
  end

  AST_S1_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R1
endmodule

// File: rtl/simd_mac_acc.sv
module simd_mac_acc
  import simd_mac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s1_valid,
  input  logic                    s1_pred,
  input  logic [2:0]              s1_op,
  input  logic [ACC_W-1:0]        s1_acc,
  input  logic [WIDE_W-1:0]       s1_wide,
  input  logic [NPROD*PROD_W-1:0] s1_lane_prod,
  output logic                    out_valid,
  output logic [ACC_W-1:0]        out_result
);
  logic signed [SUM_W-1:0] p00, p01, p10, p11;
  logic signed [SUM_W-1:0] acc_l0, acc_l1, sum0, sum1;
  logic [ACC_W-WORD_W:0]   acc_top;
  logic [ACC_W-1:0]        result_d;

  always_comb begin
    p00    = SUM_W'($signed(s1_lane_prod[0*PROD_W +: PROD_W]));
    p01    = SUM_W'($signed(s1_lane_prod[1*PROD_W +: PROD_W]));
    p10    = SUM_W'($signed(s1_lane_prod[2*PROD_W +: PROD_W]));
    p11    = SUM_W'($signed(s1_lane_prod[3*PROD_W +: PROD_W]));
    acc_l0 = SUM_W'($signed(s1_acc[0 +: LANE_W]));
    acc_l1 = SUM_W'($signed(s1_acc[LANE_W +: LANE_W]));
    acc_top = s1_acc[ACC_W-1:WORD_W-1];

    sum0 = p00;
    sum1 = p11;
    unique case (s1_op)
      OP_VMAC: begin
        sum0 = acc_l0 + p00;
        sum1 = acc_l1 + p11;
      end
      OP_CMAC: begin
        sum0 = acc_l0 + p00 - p11;
        sum1 = acc_l1 + p01 + p10;
      end
      default: ;
    endcase

    result_d = s1_acc;
    if (s1_pred) begin
      unique case (s1_op)
        OP_SMUL: result_d = s1_wide[ACC_W-1:0];
        OP_SMAC: result_d = s1_acc + s1_wide[ACC_W-1:0];
        OP_VMUL, OP_VMAC, OP_CMAC:
          result_d = {{(ACC_W-WORD_W){1'b0}}, sat_lane(sum1), sat_lane(sum0)};
        OP_SAT32: begin
          if ((&acc_top) || !(|acc_top)) result_d = s1_acc;
          else if (s1_acc[ACC_W-1])      result_d = {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
          else                           result_d = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
        end
        default: result_d = s1_acc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_result <= result_d;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(out_result)); // R12
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_pred,
  input  logic [2:0]        in_op,
  input  logic [WORD_W-1:0] in_src_a,
  input  logic [WORD_W-1:0] in_src_b,
  input  logic [ACC_W-1:0]  in_acc,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_result
);
  logic                    s1_valid, s1_pred;
  logic [2:0]              s1_op;
  logic [ACC_W-1:0]        s1_acc;
  logic [WIDE_W-1:0]       s1_wide;
  logic [NPROD*PROD_W-1:0] s1_lane_prod;

  simd_mac_mul u_mul (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_pred      (in_pred),
    .in_op        (in_op),
    .in_src_a     (in_src_a),
    .in_src_b     (in_src_b),
    .in_acc       (in_acc),
    .s1_valid     (s1_valid),
    .s1_pred      (s1_pred),
    .s1_op        (s1_op),
    .s1_acc       (s1_acc),
    .s1_wide      (s1_wide),
    .s1_lane_prod (s1_lane_prod)
  );

  simd_mac_acc u_acc (
    .clk          (clk),
    .rst_n        (rst_n),
    .s1_valid     (s1_valid),
    .s1_pred      (s1_pred),
    .s1_op        (s1_op),
    .s1_acc       (s1_acc),
    .s1_wide      (s1_wide),
    .s1_lane_prod (s1_lane_prod),
    .out_valid    (out_valid),
    .out_result   (out_result)
  );

  AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid); // R1
  AST_PRED_PASSES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_pred) |=> ##1 (out_result == $past(in_acc, 2))); // R9
  AST_LANE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pred && (in_op == OP_VMUL || in_op == OP_VMAC || in_op == OP_CMAC))
      |=> ##1 (out_result[ACC_W-1:WORD_W] == '0)); // R4
  AST_CLAMP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pred && in_op == OP_SAT32)
      |=> ##1 ((&out_result[ACC_W-1:WORD_W-1]) || !(|out_result[ACC_W-1:WORD_W-1]))); // R8
  AST_SPARE_OP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[2:1] == 2'b11) |=> ##1 (out_result == $past(in_acc, 2))); // R10
endmodule

// File: tb/simd_mac_unit_test.sv
module simd_mac_unit_test;
  typedef struct packed {
    logic [2:0]  op;
    logic        pred;
    logic [31:0] a;
    logic [31:0] b;
    logic [39:0] acc;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{3'b000, 1'b1, 32'h0000_0003, 32'hFFFF_FFFB, 40'h00_0000_0000},
    '{3'b000, 1'b1, 32'h8000_0000, 32'h8000_0000, 40'h12_3456_789A},
    '{3'b001, 1'b1, 32'h0000_0001, 32'h0000_0001, 40'h7F_FFFF_FFFF},
    '{3'b001, 1'b1, 32'h0001_2345, 32'h0000_0100, 40'hFF_FFFF_FF00},
    '{3'b010, 1'b1, 32'h8000_0003, 32'h8000_FFFE, 40'hFF_FFFF_FFFF},
    '{3'b011, 1'b1, 32'h0010_0002, 32'h0010_FFF0, 40'hAB_7FF0_8005},
    '{3'b100, 1'b1, 32'h0002_0003, 32'hFFFF_0004, 40'h00_FFFB_000A},
    '{3'b100, 1'b1, 32'h7FFF_7FFF, 32'h8000_7FFF, 40'h00_0000_0000},
    '{3'b101, 1'b1, 32'h0, 32'h0, 40'h01_0000_0000},
    '{3'b101, 1'b1, 32'h0, 32'h0, 40'h80_0000_0000},
    '{3'b101, 1'b1, 32'h0, 32'h0, 40'hFF_FFFF_F000},
    '{3'b001, 1'b0, 32'h0000_7777, 32'h0000_1234, 40'h12_3456_789A},
    '{3'b100, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 40'hC3_0000_1111},
    '{3'b110, 1'b1, 32'hDEAD_BEEF, 32'h1234_5678, 40'h55_AA55_AA55},
    '{3'b111, 1'b1, 32'h0BAD_F00D, 32'h0000_0003, 40'h80_0000_0001},
    '{3'b010, 1'b1, 32'hFFFD_0007, 32'h0005_FFF9, 40'h00_0000_0000}
  };

  logic        clk, rst_n, in_valid, in_pred;
  logic [2:0]  in_op;
  logic [31:0] in_src_a, in_src_b;
  logic [39:0] in_acc;
  logic        out_valid;
  logic [39:0] out_result;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  simd_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
    .out_valid(out_valid), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] sat16(input longint x);
    if (x > 32767)       return 16'h7FFF;
    else if (x < -32768) return 16'h8000;
    else                 return x[15:0];
  endfunction

  function automatic logic [39:0] model(input vec_t v);
    longint sa = longint'($signed(v.a));
    longint sb = longint'($signed(v.b));
    longint ar = longint'($signed(v.a[15:0]));
    longint ai = longint'($signed(v.a[31:16]));
    longint br = longint'($signed(v.b[15:0]));
    longint bi = longint'($signed(v.b[31:16]));
    longint cr = longint'($signed(v.acc[15:0]));
    longint ci = longint'($signed(v.acc[31:16]));
    longint s  = longint'($signed(v.acc));
    longint p  = sa * sb;
    if (!v.pred) return v.acc;
    case (v.op)
      3'b000: return p[39:0];
      3'b001: return v.acc + p[39:0];
      3'b010: return {8'h00, sat16(ai * bi), sat16(ar * br)};
      3'b011: return {8'h00, sat16(ci + ai * bi), sat16(cr + ar * br)};
      3'b100: return {8'h00, sat16(ci + ar * bi + ai * br), sat16(cr + ar * br - ai * bi)};
      3'b101: begin
        if (s > 64'sd2147483647)       return 40'h00_7FFF_FFFF;
        else if (s < -64'sd2147483648) return 40'hFF_8000_0000;
        else                           return v.acc;
      end
      default: return v.acc;
    endcase
  endfunction

  function automatic string tag_of(input vec_t v);
    if (!v.pred) return "R9";
    case (v.op)
      3'b000:  return "R2";
      3'b001:  return "R3";
      3'b010:  return "R5 R4";
      3'b011:  return "R6 R4";
      3'b100:  return "R7 R4";
      3'b101:  return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; in_pred = v.pred; in_op = v.op;
    in_src_a = v.a; in_src_b = v.b; in_acc = v.acc;
  endtask

  task automatic idle_garbage();
    in_valid = 1'b0; in_pred = 1'b1; in_op = 3'b001;
    in_src_a = 32'h7FFF_FFFF; in_src_b = 32'h7FFF_FFFF; in_acc = 40'hEE_EEEE_EEEE;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    rst_n = 1'b0;
    idle_garbage();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", {39'd0, out_valid}, 40'd0);
    check("R11 result", out_result, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one operation, result two edges later
    for (int k = 0; k < NVEC; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      idle_garbage();
      @(negedge clk);
      check({tag_of(VECS[k]), " valid"}, {39'd0, out_valid}, 40'd1);
      check(tag_of(VECS[k]), out_result, model(VECS[k]));
    end

    // R12: idle cycles with garbage inputs keep the result
    held = out_result;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12 idle valid", {39'd0, out_valid}, 40'd0);
      check("R12 hold", out_result, held);
    end

    // R1: back-to-back issue, one result per cycle
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[6]);
    @(negedge clk);
    check("R1 b2b first", out_result, model(VECS[2]));
    check("R1 b2b first valid", {39'd0, out_valid}, 40'd1);
    drive(VECS[9]);
    @(negedge clk);
    check("R1 b2b second", out_result, model(VECS[6]));
    idle_garbage();
    @(negedge clk);
    check("R1 b2b third", out_result, model(VECS[9]));
    check("R1 b2b third valid", {39'd0, out_valid}, 40'd1);
    @(negedge clk);
    check("R1 drain", {39'd0, out_valid}, 40'd0);

    // R11: reset in the middle of traffic
    drive(VECS[0]);
    @(negedge clk);
    rst_n = 1'b0;
    idle_garbage();
    @(negedge clk);
    check("R11 mid valid", {39'd0, out_valid}, 40'd0);
    check("R11 mid result", out_result, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 after release", {39'd0, out_valid}, 40'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule